// File: doc/BRIEF.md
# Paged Local-to-Global Address Translator

This block turns the 16-bit local address of a small CPU into a 23-bit linear global address. The local space is cut into fixed slices and windows. Three windows slide over larger memories under their own page registers: a 1 KB EEPROM window, a 4 KB RAM window and a 16 KB flash window. The other slices are fixed, and that includes one slice at 4000–7FFF that a map-control register can point at internal RAM, at fixed flash, or at the external bus.

The translation is purely combinational from the local address and the register contents. The four registers (three page registers and the map control) are loaded through a simple write port. In normal mode the map-control register accepts only its first write after reset. In special mode it can be rewritten at any time. Along with the global address the block reports a region code, and it raises a flag when a write strobe targets flash.

Top module: `pager_xlate`

## Requirements
- R1: After reset the RAM page is FD, the flash page is FE, the EEPROM page is FE and both map-control bits are 0. So local 1000 gives 0x0FD000, 8000 gives 0x7F8000, 0800 gives 0x13F800 and 4000 gives 0x7F4000.
- R2: Local 0000–07FF maps to the same global address (0x000000–0x0007FF) with region code 0 (registers).
- R3: Local 0800–0BFF maps to 0x100000 + EEPROM page × 0x400 + offset. Local 0C00–0FFF maps as if the EEPROM page were FF. Both report region code 1 (EEPROM).
- R4: Local 1000–1FFF maps to RAM page × 0x1000 + the low 12 address bits, with region code 2 (RAM).
- R5: Local 2000–3FFF maps to 0x0FE000–0x0FFFFF with region code 2, whatever the RAM page holds.
- R6: Local 8000–BFFF maps to 0x400000 + flash page × 0x4000 + the low 14 bits, with region code 3 (flash).
- R7: Local C000–FFFF maps to 0x7FC000–0x7FFFFF with region code 3, as flash page FF would.
- R8: For local 4000–7FFF, control bit 0 set gives RAM at 0x0FC000 + offset (region 2) whatever bit 1 holds. Bit 0 clear with bit 1 set gives 0x144000 + offset with region code 4 (external). Both bits clear gives flash at 0x7F4000 + offset (region 3).
- R9: With the special-mode input low, only the first write to the control register after reset changes it. Later writes leave it unchanged.
- R10: With the special-mode input high, every control write takes effect, even after the lock has been set.
- R11: `bad_write` is high exactly when `loc_wr` is high and the region code is 3.
- R12: Register writes use `cfg_sel` 0 = RAM page, 1 = flash page, 2 = EEPROM page, 3 = control (bit 0 = RAM in 4000–7FFF, bit 1 = fixed flash removed from 4000–7FFF). A write takes effect at the clock edge where `cfg_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| special_mode | input | 1 | High lets the control register be rewritten freely |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 8 | Register write data |
| loc_addr | input | 16 | Local CPU address |
| loc_wr | input | 1 | Access is a write |
| glb_addr | output | 23 | Translated global address |
| region | output | 3 | Region code: 0 reg, 1 EEPROM, 2 RAM, 3 flash, 4 external |
| bad_write | output | 1 | Write strobe aimed at flash |

## Verification
Full sweeps of the local space, with a varying offset inside each 64-byte step, are repeated under several register settings. These are the reset pages, and then non-default pages whose bits differ in every nibble, so a page register placed in the wrong window or shifted by a bit changes the result. The sweeps also cover each of the four settings of the control bits, which separates the RAM, external and fixed-flash routes of the 4000–7FFF slice and the priority of bit 0. Control writes are interleaved in normal and special mode to tell apart a lock that never sets, a lock that also blocks special mode, and a lock that only counts normal-mode writes. The write strobe alternates within every sweep, so the illegal-write flag is seen against every region.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

   typedef enum logic [2:0] {
      RGN_REG   = 3'd0,
      RGN_EE    = 3'd1,
      RGN_RAM   = 3'd2,
      RGN_FLASH = 3'd3,
      RGN_EXT   = 3'd4
   } region_t;

   typedef enum logic [2:0] {
      SL_REG,
      SL_EEWIN,
      SL_EEFIX,
      SL_RAMWIN,
      SL_RAMFIX,
      SL_HIGH,
      SL_ROMWIN,
      SL_ROMFIX
   } slot_t;

   localparam logic [1:0] SEL_RAMPG = 2'd0;
   localparam logic [1:0] SEL_ROMPG = 2'd1;
   localparam logic [1:0] SEL_EEPG  = 2'd2;
   localparam logic [1:0] SEL_CTL   = 2'd3;

endpackage

// File: rtl/pgx_cfg_regs.sv
module pgx_cfg_regs
   import pgx_pkg::*;
#(
   parameter int            PG_W       = 8,
   parameter bit            WRITE_ONCE = 1'b1,
   parameter logic [PG_W-1:0] RST_RAM  = 8'hFD,
   parameter logic [PG_W-1:0] RST_ROM  = 8'hFE,
   parameter logic [PG_W-1:0] RST_EE   = 8'hFE
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            special_mode,
   input  logic            we,
   input  logic [1:0]      sel,
   input  logic [PG_W-1:0] wdata,
   output logic [PG_W-1:0] ram_pg,
   output logic [PG_W-1:0] rom_pg,
   output logic [PG_W-1:0] ee_pg,
   output logic            hi_ram,
   output logic            hi_rom_off
);

   if (PG_W < 2) begin : g_chk_w
      $error("pgx_cfg_regs: PG_W must hold the two control bits");
   end

   logic       ctl_hit;
   logic [1:0] ctl_q;

   assign ctl_hit = we && (sel == SEL_CTL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ram_pg <= RST_RAM;
         rom_pg <= RST_ROM;
         ee_pg  <= RST_EE;
      end else if (we) begin
         case (sel)
            SEL_RAMPG: ram_pg <= wdata;
            SEL_ROMPG: rom_pg <= wdata;
            SEL_EEPG:  ee_pg  <= wdata;
            default:   ;
         endcase
      end
   end

   if (WRITE_ONCE) begin : g_once
      logic locked_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ctl_q    <= 2'b00;
            locked_q <= 1'b0;
         end else begin
            if (ctl_hit && (special_mode || !locked_q))
               ctl_q <= wdata[1:0];
            if (ctl_hit && !special_mode)
               locked_q <= 1'b1;
         end
      end
   end else begin : g_free
      always_ff @(posedge clk) begin
         if (!rst_n)
            ctl_q <= 2'b00;
         else if (ctl_hit)
            ctl_q <= wdata[1:0];
      end
   end

   assign hi_ram     = ctl_q[0];
   assign hi_rom_off = ctl_q[1];

endmodule

// File: rtl/pgx_slot_dec.sv
module pgx_slot_dec
   import pgx_pkg::*;
(
   input  logic [5:0] a_hi,
   output slot_t      slot
);

   always_comb begin
      unique casez (a_hi)
         6'b11????: slot = SL_ROMFIX;
         6'b10????: slot = SL_ROMWIN;
         6'b01????: slot = SL_HIGH;
         6'b001???: slot = SL_RAMFIX;
         6'b0001??: slot = SL_RAMWIN;
         6'b000011: slot = SL_EEFIX;
         6'b000010: slot = SL_EEWIN;
         default:   slot = SL_REG;
      endcase
   end

endmodule

// File: rtl/pgx_compose.sv
module pgx_compose
   import pgx_pkg::*;
#(
   parameter int PG_W = 8,
   parameter int LAW  = 16,
   parameter int GAW  = 23
) (
   input  slot_t           slot,
   input  logic [LAW-1:0]  a,
   input  logic [PG_W-1:0] ram_pg,
   input  logic [PG_W-1:0] rom_pg,
   input  logic [PG_W-1:0] ee_pg,
   input  logic            hi_ram,
   input  logic            hi_rom_off,
   output logic [GAW-1:0]  glb,
   output region_t         rgn
);

   localparam int ROM_OFS_W = GAW - PG_W - 1;
   localparam logic [GAW-1:0]  EE_BASE   = GAW'(32'h0010_0000);
   localparam logic [GAW-1:0]  RAM_TOP   = GAW'(32'h000F_C000);
   localparam logic [GAW-1:0]  EXT_BASE  = GAW'(32'h0014_0000);
   localparam logic [PG_W-1:0] LOW_FIXPG = PG_W'(8'hFD);
   localparam logic [PG_W-1:0] ALL_ONES  = '1;

   logic [GAW-1:0] rom_fix_lo, rom_fix_hi, rom_win, ram_top_a;

   assign rom_fix_lo = {1'b1, LOW_FIXPG, a[ROM_OFS_W-1:0]};
   assign rom_fix_hi = {1'b1, ALL_ONES,  a[ROM_OFS_W-1:0]};
   assign rom_win    = {1'b1, rom_pg,    a[ROM_OFS_W-1:0]};
   assign ram_top_a  = RAM_TOP | GAW'(a[13:0]);

   always_comb begin
      glb = '0;
      rgn = RGN_REG;
      unique case (slot)
         SL_REG: begin
            glb = GAW'(a[10:0]);
            rgn = RGN_REG;
         end
         SL_EEWIN: begin
            glb = EE_BASE | GAW'({ee_pg, a[9:0]});
            rgn = RGN_EE;
         end
         SL_EEFIX: begin
            glb = EE_BASE | GAW'({ALL_ONES, a[9:0]});
            rgn = RGN_EE;
         end
         SL_RAMWIN: begin
            glb = GAW'({ram_pg, a[11:0]});
            rgn = RGN_RAM;
         end
         SL_RAMFIX: begin
            glb = ram_top_a;
            rgn = RGN_RAM;
         end
         SL_HIGH: begin
            if (hi_ram) begin
               glb = ram_top_a;
               rgn = RGN_RAM;
            end else if (hi_rom_off) begin
               glb = EXT_BASE | GAW'(a);
               rgn = RGN_EXT;
            end else begin
               glb = rom_fix_lo;
               rgn = RGN_FLASH;
            end
         end
         SL_ROMWIN: begin
            glb = rom_win;
            rgn = RGN_FLASH;
         end
         SL_ROMFIX: begin
            glb = rom_fix_hi;
            rgn = RGN_FLASH;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/pager_xlate.sv
module pager_xlate
   import pgx_pkg::*;
#(
   parameter int              PG_W       = 8,
   parameter int              LAW        = 16,
   parameter int              GAW        = 23,
   parameter bit              WRITE_ONCE = 1'b1,
   parameter logic [PG_W-1:0] RST_RAM    = 8'hFD,
   parameter logic [PG_W-1:0] RST_ROM    = 8'hFE,
   parameter logic [PG_W-1:0] RST_EE     = 8'hFE
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            special_mode,
   input  logic            cfg_we,
   input  logic [1:0]      cfg_sel,
   input  logic [PG_W-1:0] cfg_wdata,
   input  logic [LAW-1:0]  loc_addr,
   input  logic            loc_wr,
   output logic [GAW-1:0]  glb_addr,
   output logic [2:0]      region,
   output logic            bad_write
);

   if (LAW != 16) begin : g_chk_law
      $error("pager_xlate: local map is laid out for 16 address bits");
   end
   if (GAW != PG_W + 15) begin : g_chk_gaw
      $error("pager_xlate: GAW must equal flash page width + 15");
   end
   if (PG_W + 12 > GAW) begin : g_chk_ram
      $error("pager_xlate: RAM window does not fit in the global space");
   end

   logic [PG_W-1:0] ram_pg, rom_pg, ee_pg;
   logic            hi_ram, hi_rom_off;
   slot_t           slot;
   region_t         rgn;

   pgx_cfg_regs #(
      .PG_W(PG_W), .WRITE_ONCE(WRITE_ONCE),
      .RST_RAM(RST_RAM), .RST_ROM(RST_ROM), .RST_EE(RST_EE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
      .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .ram_pg(ram_pg), .rom_pg(rom_pg), .ee_pg(ee_pg),
      .hi_ram(hi_ram), .hi_rom_off(hi_rom_off)
   );

   pgx_slot_dec u_dec (
      .a_hi(loc_addr[LAW-1:LAW-6]),
      .slot(slot)
   );

   pgx_compose #(.PG_W(PG_W), .LAW(LAW), .GAW(GAW)) u_map (
      .slot(slot), .a(loc_addr),
      .ram_pg(ram_pg), .rom_pg(rom_pg), .ee_pg(ee_pg),
      .hi_ram(hi_ram), .hi_rom_off(hi_rom_off),
      .glb(glb_addr), .rgn(rgn)
   );

   assign region    = rgn;
   assign bad_write = loc_wr && (rgn == RGN_FLASH);

endmodule

// File: rtl/pgx_checks.sv
module pgx_checks #(
   parameter int LAW = 16,
   parameter int GAW = 23
) (
   input logic           clk,
   input logic           rst_n,
   input logic           special_mode,
   input logic           cfg_we,
   input logic [1:0]     cfg_sel,
   input logic [LAW-1:0] loc_addr,
   input logic           loc_wr,
   input logic [GAW-1:0] glb_addr,
   input logic [2:0]     region,
   input logic           bad_write,
   input logic [1:0]     ctl_q
);

   logic seen_normal_ctl;
   logic ctl_wr_normal;

   assign ctl_wr_normal = cfg_we && (cfg_sel == 2'd3) && !special_mode;

   always_ff @(posedge clk) begin
      if (!rst_n)
         seen_normal_ctl <= 1'b0;
      else if (ctl_wr_normal)
         seen_normal_ctl <= 1'b1;
   end

   assert_reg_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_addr < 16'h0800) |-> (glb_addr == GAW'(loc_addr) && region == 3'd0));

   assert_ram_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_addr[15:12] == 4'h1) |->
         (region == 3'd2 && glb_addr[11:0] == loc_addr[11:0] && glb_addr[GAW-1:20] == '0));

   assert_ram_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_addr[15:13] == 3'b001) |->
         (region == 3'd2 && glb_addr == (GAW'(32'h000F_C000) | GAW'(loc_addr[13:0]))));

   assert_flash_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_addr[15:14] == 2'b10) |->
         (region == 3'd3 && glb_addr[GAW-1] && glb_addr[13:0] == loc_addr[13:0]));

   assert_flash_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_addr[15:14] == 2'b11) |->
         (region == 3'd3 && glb_addr == (GAW'(32'h007F_C000) | GAW'(loc_addr[13:0]))));

   assert_badwr_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      bad_write |-> (loc_wr && region == 3'd3));

   assert_badwr_seen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_wr && region == 3'd3) |-> bad_write);

   assert_ctl_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr_normal && seen_normal_ctl) |=> $stable(ctl_q));

endmodule

bind pager_xlate pgx_checks #(.LAW(LAW), .GAW(GAW)) u_chk (
   .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
   .cfg_we(cfg_we), .cfg_sel(cfg_sel), .loc_addr(loc_addr), .loc_wr(loc_wr),
   .glb_addr(glb_addr), .region(region), .bad_write(bad_write),
   .ctl_q({hi_rom_off, hi_ram})
);

// File: tb/sim_pager_xlate.sv
module sim_pager_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        special_mode = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [7:0]  cfg_wdata = 8'd0;
   logic [15:0] loc_addr = 16'd0;
   logic        loc_wr = 1'b0;
   logic [22:0] glb_addr;
   logic [2:0]  region;
   logic        bad_write;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [7:0] m_rpg = 8'hFD, m_ppg = 8'hFE, m_epg = 8'hFE;
   logic [1:0] m_ctl = 2'b00;
   bit         m_locked = 1'b0;

   always #2 clk = ~clk;

   pager_xlate u0 (
      .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .loc_addr(loc_addr), .loc_wr(loc_wr),
      .glb_addr(glb_addr), .region(region), .bad_write(bad_write)
   );

   task automatic model(input int unsigned a, input bit wr,
                        output int unsigned g, output int unsigned rg,
                        output bit b, output string tag);
      if (a < 32'h800) begin
         g = a; rg = 0; tag = "R2";
      end else if (a < 32'hC00) begin
         g = 32'h100000 + m_epg * 32'h400 + (a - 32'h800); rg = 1; tag = "R3";
      end else if (a < 32'h1000) begin
         g = 32'h100000 + 32'hFF * 32'h400 + (a - 32'hC00); rg = 1; tag = "R3";
      end else if (a < 32'h2000) begin
         g = m_rpg * 32'h1000 + (a - 32'h1000); rg = 2; tag = "R4";
      end else if (a < 32'h4000) begin
         g = 32'h0FE000 + (a - 32'h2000); rg = 2; tag = "R5";
      end else if (a < 32'h8000) begin
         tag = "R8";
         if (m_ctl[0]) begin
            g = 32'h0FC000 + (a - 32'h4000); rg = 2;
         end else if (m_ctl[1]) begin
            g = 32'h144000 + (a - 32'h4000); rg = 4;
         end else begin
            g = 32'h7F4000 + (a - 32'h4000); rg = 3;
         end
      end else if (a < 32'hC000) begin
         g = 32'h400000 + m_ppg * 32'h4000 + (a - 32'h8000); rg = 3; tag = "R6";
      end else begin
         g = 32'h7FC000 + (a - 32'hC000); rg = 3; tag = "R7";
      end
      b = wr && (rg == 3);
   endtask

   task automatic probe(input logic [15:0] a, input bit wr, input string why);
      int unsigned g, rg;
      bit b;
      string tag;
      @(negedge clk);
      loc_addr = a;
      loc_wr   = wr;
      #1;
      model(a, wr, g, rg, b, tag);
      checks++;
      if (glb_addr !== g[22:0] || region !== rg[2:0] || bad_write !== b) begin
         fails++;
         $display("FAIL %s/R11 %s addr=%h wr=%0d: got glb=%h rgn=%0d bad=%0d exp glb=%h rgn=%0d bad=%0d",
                  tag, why, a, wr, glb_addr, region, bad_write, g[22:0], rg, b);
      end
   endtask

   task automatic sweep(input string why);
      for (int i = 0; i < 1024; i++) begin
         logic [15:0] a;
         a = 16'(i * 64 + ((i * 13) & 63));
         probe(a, i[0], why);
      end
      probe(16'h07FF, 1'b1, why);
      probe(16'h0FFF, 1'b0, why);
      probe(16'h1FFF, 1'b1, why);
      probe(16'h7FFF, 1'b1, why);
      probe(16'hBFFF, 1'b1, why);
      probe(16'hFFFF, 1'b1, why);
   endtask

   // R12: select codes 0..3 address RAM page, flash page, EEPROM page, control
   task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
      case (sel)
         2'd0: m_rpg = d;
         2'd1: m_ppg = d;
         2'd2: m_epg = d;
         default: begin
            if (special_mode || !m_locked) m_ctl = d[1:0];
            if (!special_mode) m_locked = 1'b1;
         end
      endcase
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_sel   = sel;
      cfg_wdata = d;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values seen through the map
      probe(16'h1000, 1'b0, "R1 reset ram page");
      probe(16'h8000, 1'b0, "R1 reset flash page");
      probe(16'h0800, 1'b0, "R1 reset eeprom page");
      probe(16'h4000, 1'b1, "R1 reset control");
      sweep("R1 reset map");

      // R4 R6 R3 R12: non-default pages
      cfg_write(2'd0, 8'hF9);
      cfg_write(2'd1, 8'h5A);
      cfg_write(2'd2, 8'h36);
      probe(16'h1000, 1'b0, "R4 page F9");
      sweep("R12 new pages");
      cfg_write(2'd0, 8'h81);
      cfg_write(2'd1, 8'hA5);
      cfg_write(2'd2, 8'hC9);
      sweep("R12 second pages");

      // R8: external route, first normal write locks
      cfg_write(2'd3, 8'h02);
      sweep("R8 external");
      // R9: later normal write ignored
      cfg_write(2'd3, 8'h01);
      probe(16'h4000, 1'b0, "R9 lock held");
      probe(16'h6ABC, 1'b1, "R9 lock held");

      // R10: special mode rewrites
      special_mode = 1'b1;
      cfg_write(2'd3, 8'h01);
      sweep("R10 ram high");
      cfg_write(2'd3, 8'h03);
      sweep("R8 both bits");
      cfg_write(2'd3, 8'h00);
      sweep("R10 back to flash");
      special_mode = 1'b0;
      // R9: still locked after leaving special mode
      cfg_write(2'd3, 8'h02);
      probe(16'h5000, 1'b1, "R9 lock after special");
      probe(16'h7000, 1'b0, "R9 lock after special");

      // R1: a fresh reset restores defaults and clears the lock
      @(negedge clk);
      rst_n = 1'b0;
      m_rpg = 8'hFD; m_ppg = 8'hFE; m_epg = 8'hFE; m_ctl = 2'b00; m_locked = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      probe(16'h1234, 1'b0, "R1 second reset");
      probe(16'h9234, 1'b1, "R1 second reset");
      cfg_write(2'd3, 8'h01);
      probe(16'h4100, 1'b1, "R9 first write after reset");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, got timeout exp completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule